// File: doc/BRIEF.md
# Exception Entry Controller

This block owns the exception-side control state of a pipelined 32-bit core. When the core raises an exception, the block takes the request in one clock edge. It records where execution stopped and why. It saves the faulting address where translation software can reach it and rotates the shadow register set selectors. It then hands the fetch stage a three-deep redirect (handler, handler + 4, handler + 8) in a single-cycle pulse.

The request carries:
- an exception class,
- the faulting PC and the PC that would have followed it,
- the bad virtual address,
- a coprocessor number.

Configuration arrives from neighbouring control registers:
- the exception base,
- the boot-vector select,
- the interrupt-vector select,
- the current address-space ID,
- the shadow set to use for exceptions.

After reset the block issues one redirect to the reset vector and marks coprocessor 1 usable.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset is released, the first clock edge produces a one-cycle redirect pulse with PC 0xBFC00000, next PC 0xBFC00004 and next-next PC 0xBFC00008. `status_cop1_usable` is 1, `status_exl` is 0, and the shadow set selectors are 0.
- R2: A request with `req_valid` high and a legal class (0 to 13) is accepted on a clock edge at which no redirect pulse is showing. The pulse appears in the following cycle for exactly one cycle. Requests seen while the pulse shows, requests during the boot cycle, and requests with class 14 or 15 change nothing.
- R3: Every accepted exception sets `status_exl` to 1, whatever its previous value.
- R4: If faulting PC + 4 differs from the next PC, then `epc` takes faulting PC − 4 and `cause_bd` is 1. Otherwise `epc` takes the faulting PC and `cause_bd` is 0.
- R5: `cause_code` takes a value set by class. Interrupt (class 0) gives 0 and TLB modified (1) gives 1. Load/fetch refill (2) and load/fetch invalid (3) give 2. Store refill (4) and store invalid (5) give 3. Load address error (6) gives 4 and store address error (7) gives 5. Syscall (8), breakpoint (9), reserved instruction (10), coprocessor unusable (11), overflow (12) and trap (13) each give their own class number.
- R6: `cause_ce` takes `req_cop_id` for class 11 and is cleared for every other accepted class.
- R7: With `cfg_bev` = 1 the handler is 0xBFC00200 for every class. Otherwise the default handler is `cfg_ebase` + 0x180.
- R8: With `cfg_bev` = 0, a refill (class 2 or 4) taken while `status_exl` was 0 before entry goes to `cfg_ebase` + 0. If `status_exl` was already 1 it goes to `cfg_ebase` + 0x180.
- R9: With `cfg_bev` = 0, an interrupt with `cfg_iv` = 1 goes to `cfg_ebase` + 0x200.
- R10: Classes 1 to 7 load `bad_vaddr` with `req_bad_addr`. Other classes leave it unchanged.
- R11: Classes 1 to 5 load `entryhi_vpn2` and `context_badvpn2` with bits 31:13 of `req_bad_addr`, and load `entryhi_asid` with `cfg_asid`. Other classes leave all three unchanged.
- R12: When `status_exl` (before entry) and `cfg_bev` are both 0, entry copies `srs_cur` into `srs_prev` and loads `srs_cur` from `cfg_exc_set`. Otherwise both selectors hold.
- R13: During every redirect pulse, `redir_npc` = `redir_pc` + 4 and `redir_nnpc` = `redir_pc` + 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request present |
| req_class | input | 4 | Exception class, 0 to 13 legal |
| req_pc | input | 32 | PC of the faulting instruction |
| req_next_pc | input | 32 | PC that would have followed |
| req_bad_addr | input | 32 | Faulting virtual address |
| req_cop_id | input | 2 | Coprocessor that raised an unusable fault |
| cfg_ebase | input | 32 | Exception base, low 12 bits zero |
| cfg_bev | input | 1 | Boot vectors selected |
| cfg_iv | input | 1 | Dedicated interrupt vector selected |
| cfg_asid | input | 8 | Current address-space ID |
| cfg_exc_set | input | 4 | Shadow set used for exceptions |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_pc | output | 32 | Redirect PC |
| redir_npc | output | 32 | Redirect PC + 4 |
| redir_nnpc | output | 32 | Redirect PC + 8 |
| status_exl | output | 1 | Exception level |
| status_cop1_usable | output | 1 | Coprocessor 1 usable (status bit 29) |
| cause_bd | output | 1 | Fault was in a delay slot |
| cause_code | output | 5 | Exception code |
| cause_ce | output | 2 | Coprocessor number of an unusable fault |
| epc | output | 32 | Restart PC |
| bad_vaddr | output | 32 | Saved faulting address |
| entryhi_vpn2 | output | 19 | Saved virtual page pair number |
| entryhi_asid | output | 8 | Saved address-space ID |
| context_badvpn2 | output | 19 | Page pair number for the refill handler |
| srs_cur | output | 4 | Current shadow set |
| srs_prev | output | 4 | Previous shadow set |

## Verification
The assertions assume several things about the inputs:
- `cfg_ebase` has its low 12 bits clear.
- PCs are word aligned.
- The class and configuration inputs are known whenever `req_valid` is high.
- Nothing else clears `status_exl`; only reset does.

The stimulus draws aligned PCs and 4 KiB-aligned bases. It picks the next PC as either the sequential address or a different aligned value. It pulses reset at random points so that entries with the exception level clear recur. Directed cases cover illegal classes and requests issued during the redirect pulse.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;

    localparam int CLS_W  = 4;
    localparam int CODE_W = 5;

    typedef enum logic [CLS_W-1:0] {
        EXC_INTR          = 4'd0,
        EXC_TLB_MOD       = 4'd1,
        EXC_TLB_REFILL_LD = 4'd2,
        EXC_TLB_INVAL_LD  = 4'd3,
        EXC_TLB_REFILL_ST = 4'd4,
        EXC_TLB_INVAL_ST  = 4'd5,
        EXC_ADDR_LD       = 4'd6,
        EXC_ADDR_ST       = 4'd7,
        EXC_SYSCALL       = 4'd8,
        EXC_BREAK         = 4'd9,
        EXC_RESV_INSN     = 4'd10,
        EXC_COP_UNUSABLE  = 4'd11,
        EXC_OVERFLOW      = 4'd12,
        EXC_TRAP          = 4'd13
    } exc_class_e;

    // fixed vectors and offsets from the exception base
    localparam logic [31:0] RESET_VEC     = 32'hBFC0_0000;
    localparam logic [31:0] BOOT_GEN_VEC  = 32'hBFC0_0200;
    localparam logic [31:0] OFS_REFILL    = 32'h0000_0000;
    localparam logic [31:0] OFS_GENERAL   = 32'h0000_0180;
    localparam logic [31:0] OFS_INTVEC    = 32'h0000_0200;

    // decoded properties of one exception class
    typedef struct packed {
        logic              legal;
        logic [CODE_W-1:0] code;
        logic              tlb;
        logic              refill;
        logic              save_bva;
        logic              intr;
        logic              cop;
    } exc_attr_t;

endpackage

// File: rtl/exc_class_decode.sv
`timescale 1ns/1ps
module exc_class_decode
    import exc_entry_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output exc_attr_t        attr
);

    always_comb begin
        attr          = '0;
        attr.legal    = 1'b1;
        case (cls)
            EXC_INTR: begin
                attr.intr = 1'b1;
            end
            EXC_TLB_MOD: begin
                attr.code     = CODE_W'(1);
                attr.tlb      = 1'b1;
                attr.save_bva = 1'b1;
            end
            EXC_TLB_REFILL_LD: begin
                attr.code     = CODE_W'(2);
                attr.tlb      = 1'b1;
                attr.refill   = 1'b1;
                attr.save_bva = 1'b1;
            end
            EXC_TLB_INVAL_LD: begin
                attr.code     = CODE_W'(2);
                attr.tlb      = 1'b1;
                attr.save_bva = 1'b1;
            end
            EXC_TLB_REFILL_ST: begin
                attr.code     = CODE_W'(3);
                attr.tlb      = 1'b1;
                attr.refill   = 1'b1;
                attr.save_bva = 1'b1;
            end
            EXC_TLB_INVAL_ST: begin
                attr.code     = CODE_W'(3);
                attr.tlb      = 1'b1;
                attr.save_bva = 1'b1;
            end
            EXC_ADDR_LD: begin
                attr.code     = CODE_W'(4);
                attr.save_bva = 1'b1;
            end
            EXC_ADDR_ST: begin
                attr.code     = CODE_W'(5);
                attr.save_bva = 1'b1;
            end
            EXC_SYSCALL:      attr.code = CODE_W'(8);
            EXC_BREAK:        attr.code = CODE_W'(9);
            EXC_RESV_INSN:    attr.code = CODE_W'(10);
            EXC_COP_UNUSABLE: begin
                attr.code = CODE_W'(11);
                attr.cop  = 1'b1;
            end
            EXC_OVERFLOW:     attr.code = CODE_W'(12);
            EXC_TRAP:         attr.code = CODE_W'(13);
            default:          attr.legal = 1'b0;
        endcase
    end

    // a refill is always a translation-class exception
    always_comb begin
        if (attr.refill) begin
            AST_REFILL_IS_TLB: assert (attr.tlb && attr.save_bva); // R11
        end
    end

endmodule

// File: rtl/exc_vector_sel.sv
`timescale 1ns/1ps
module exc_vector_sel
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] ebase,
    input  logic            bev,
    input  logic            iv,
    input  logic            exl_pre,
    input  logic            refill,
    input  logic            intr,
    output logic [XLEN-1:0] handler
);

    // boot vectors win; refill offset needs the level from before entry
    always_comb begin
        if (bev) begin
            handler = XLEN'(BOOT_GEN_VEC);
        end else if (refill && !exl_pre) begin
            handler = ebase + XLEN'(OFS_REFILL);
        end else if (intr && iv) begin
            handler = ebase + XLEN'(OFS_INTVEC);
        end else begin
            handler = ebase + XLEN'(OFS_GENERAL);
        end
    end

endmodule

// File: rtl/exc_epc_calc.sv
`timescale 1ns/1ps
module exc_epc_calc #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] fault_pc,
    input  logic [XLEN-1:0] next_pc,
    output logic            in_slot,
    output logic [XLEN-1:0] restart_pc
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    // a non-sequential successor means the fault sat behind a branch
    always_comb begin
        in_slot    = (fault_pc + STEP) != next_pc;
        restart_pc = in_slot ? (fault_pc - STEP) : fault_pc;
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ASID_W     = 8,
    parameter int SET_W      = 4,
    parameter int COP_W      = 2,
    parameter int PAGE_LSB   = 13,
    parameter int INSN_BYTES = 4,
    parameter int REDIR_N    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [CLS_W-1:0]         req_class,
    input  logic [XLEN-1:0]          req_pc,
    input  logic [XLEN-1:0]          req_next_pc,
    input  logic [XLEN-1:0]          req_bad_addr,
    input  logic [COP_W-1:0]         req_cop_id,
    input  logic [XLEN-1:0]          cfg_ebase,
    input  logic                     cfg_bev,
    input  logic                     cfg_iv,
    input  logic [ASID_W-1:0]        cfg_asid,
    input  logic [SET_W-1:0]         cfg_exc_set,
    output logic                     redir_valid,
    output logic [XLEN-1:0]          redir_pc,
    output logic [XLEN-1:0]          redir_npc,
    output logic [XLEN-1:0]          redir_nnpc,
    output logic                     status_exl,
    output logic                     status_cop1_usable,
    output logic                     cause_bd,
    output logic [CODE_W-1:0]        cause_code,
    output logic [COP_W-1:0]         cause_ce,
    output logic [XLEN-1:0]          epc,
    output logic [XLEN-1:0]          bad_vaddr,
    output logic [XLEN-PAGE_LSB-1:0] entryhi_vpn2,
    output logic [ASID_W-1:0]        entryhi_asid,
    output logic [XLEN-PAGE_LSB-1:0] context_badvpn2,
    output logic [SET_W-1:0]         srs_cur,
    output logic [SET_W-1:0]         srs_prev
);

    localparam int              VPN_W = XLEN - PAGE_LSB;
    localparam logic [XLEN-1:0] STEP  = XLEN'(INSN_BYTES);

    typedef struct packed {
        logic                          boot;
        logic                          redir_valid;
        logic [REDIR_N-1:0][XLEN-1:0]  redir;
        logic                          exl;
        logic                          cu1;
        logic                          bd;
        logic [CODE_W-1:0]             code;
        logic [COP_W-1:0]              ce;
        logic [XLEN-1:0]               epc;
        logic [XLEN-1:0]               bva;
        logic [VPN_W-1:0]              vpn2;
        logic [ASID_W-1:0]             asid;
        logic [VPN_W-1:0]              ctx_vpn2;
        logic [SET_W-1:0]              css;
        logic [SET_W-1:0]              pss;
    } state_t;

    state_t    st_d, st_q;
    exc_attr_t attr;
    logic      accept;
    logic      in_slot;
    logic [XLEN-1:0] restart_pc;
    logic [XLEN-1:0] handler;
    logic [REDIR_N-1:0][XLEN-1:0] seq_pcs;

    exc_class_decode u_decode (
        .cls  (req_class),
        .attr (attr)
    );

    exc_epc_calc #(
        .XLEN       (XLEN),
        .INSN_BYTES (INSN_BYTES)
    ) u_epc (
        .fault_pc   (req_pc),
        .next_pc    (req_next_pc),
        .in_slot    (in_slot),
        .restart_pc (restart_pc)
    );

    exc_vector_sel #(
        .XLEN (XLEN)
    ) u_vector (
        .ebase   (cfg_ebase),
        .bev     (cfg_bev),
        .iv      (cfg_iv),
        .exl_pre (st_q.exl),
        .refill  (attr.refill),
        .intr    (attr.intr),
        .handler (handler)
    );

    // sequential fetch addresses following the handler
    always_comb begin
        for (int i = 0; i < REDIR_N; i++) begin
            seq_pcs[i] = handler + XLEN'(i) * STEP;
        end
    end

    assign accept = req_valid && attr.legal && !st_q.boot && !st_q.redir_valid;

    always_comb begin
        st_d             = st_q;
        st_d.boot        = 1'b0;
        st_d.redir_valid = 1'b0;
        if (st_q.boot) begin
            st_d.redir_valid = 1'b1;
        end else if (accept) begin
            st_d.redir_valid = 1'b1;
            st_d.redir       = seq_pcs;
            st_d.exl         = 1'b1;
            if (!st_q.exl && !cfg_bev) begin
                st_d.pss = st_q.css;
                st_d.css = cfg_exc_set;
            end
            st_d.bd   = in_slot;
            st_d.epc  = restart_pc;
            st_d.code = attr.code;
            st_d.ce   = attr.cop ? req_cop_id : '0;
            if (attr.save_bva) begin
                st_d.bva = req_bad_addr;
            end
            if (attr.tlb) begin
                st_d.vpn2     = req_bad_addr[XLEN-1:PAGE_LSB];
                st_d.ctx_vpn2 = req_bad_addr[XLEN-1:PAGE_LSB];
                st_d.asid     = cfg_asid;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.boot <= 1'b1;
            st_q.cu1  <= 1'b1;
            for (int i = 0; i < REDIR_N; i++) begin
                st_q.redir[i] <= XLEN'(RESET_VEC) + XLEN'(i) * STEP;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign redir_valid        = st_q.redir_valid;
    assign redir_pc           = st_q.redir[0];
    assign redir_npc          = st_q.redir[1];
    assign redir_nnpc         = st_q.redir[2];
    assign status_exl         = st_q.exl;
    assign status_cop1_usable = st_q.cu1;
    assign cause_bd           = st_q.bd;
    assign cause_code         = st_q.code;
    assign cause_ce           = st_q.ce;
    assign epc                = st_q.epc;
    assign bad_vaddr          = st_q.bva;
    assign entryhi_vpn2       = st_q.vpn2;
    assign entryhi_asid       = st_q.asid;
    assign context_badvpn2    = st_q.ctx_vpn2;
    assign srs_cur            = st_q.css;
    assign srs_prev           = st_q.pss;

    AST_EXL_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> status_exl); // R3

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !redir_valid); // R2

    AST_BUSY_HOLDS_EPC: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> $stable(epc) && $stable(cause_code)); // R2

    AST_SEQ_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (redir_npc == redir_pc + STEP) &&
                        (redir_nnpc == redir_pc + 2 * STEP)); // R13

    AST_DELAY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_pc + STEP != req_next_pc)) |=>
            cause_bd && (epc == $past(req_pc) - STEP)); // R4

    AST_SRS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (status_exl || cfg_bev)) |=>
            $stable(srs_cur) && $stable(srs_prev)); // R12

    AST_BEV_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cfg_bev) |=> redir_pc == XLEN'(BOOT_GEN_VEC)); // R7

    AST_CE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_class != EXC_COP_UNUSABLE) |=> cause_ce == '0); // R6

endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_class = '0;
    logic [31:0] req_pc = '0, req_next_pc = '0, req_bad_addr = '0;
    logic [1:0]  req_cop_id = '0;
    logic [31:0] cfg_ebase = 32'h8000_0000;
    logic        cfg_bev = 1'b0, cfg_iv = 1'b0;
    logic [7:0]  cfg_asid = '0;
    logic [3:0]  cfg_exc_set = '0;

    logic        redir_valid, status_exl, status_cop1_usable, cause_bd;
    logic [31:0] redir_pc, redir_npc, redir_nnpc, epc, bad_vaddr;
    logic [4:0]  cause_code;
    logic [1:0]  cause_ce;
    logic [18:0] entryhi_vpn2, context_badvpn2;
    logic [7:0]  entryhi_asid;
    logic [3:0]  srs_cur, srs_prev;

    always #5 clk = ~clk;

    exc_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
        .req_pc(req_pc), .req_next_pc(req_next_pc), .req_bad_addr(req_bad_addr),
        .req_cop_id(req_cop_id), .cfg_ebase(cfg_ebase), .cfg_bev(cfg_bev),
        .cfg_iv(cfg_iv), .cfg_asid(cfg_asid), .cfg_exc_set(cfg_exc_set),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_npc(redir_npc),
        .redir_nnpc(redir_nnpc), .status_exl(status_exl),
        .status_cop1_usable(status_cop1_usable), .cause_bd(cause_bd),
        .cause_code(cause_code), .cause_ce(cause_ce), .epc(epc),
        .bad_vaddr(bad_vaddr), .entryhi_vpn2(entryhi_vpn2),
        .entryhi_asid(entryhi_asid), .context_badvpn2(context_badvpn2),
        .srs_cur(srs_cur), .srs_prev(srs_prev)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference state
    logic        m_exl, m_bd;
    logic [4:0]  m_code;
    logic [1:0]  m_ce;
    logic [31:0] m_epc, m_bva;
    logic [18:0] m_vpn, m_ctx;
    logic [7:0]  m_asid;
    logic [3:0]  m_css, m_pss;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_code(input logic [3:0] c);
        case (c)
            4'd0: return 5'd0;
            4'd1: return 5'd1;
            4'd2, 4'd3: return 5'd2;
            4'd4, 4'd5: return 5'd3;
            4'd6: return 5'd4;
            4'd7: return 5'd5;
            default: return {1'b0, c};
        endcase
    endfunction

    function automatic logic [31:0] exp_handler(input logic [3:0] c, input logic exl_pre,
                                                input logic bev, input logic iv,
                                                input logic [31:0] base);
        if (bev) return 32'hBFC0_0200;
        if ((c == 4'd2 || c == 4'd4) && !exl_pre) return base;
        if (c == 4'd0 && iv) return base + 32'h200;
        return base + 32'h180;
    endfunction

    task automatic check_state(input string when);
        chk({"R3 exl ", when}, {31'd0, status_exl}, {31'd0, m_exl});
        chk({"R1 cop1 usable ", when}, {31'd0, status_cop1_usable}, 32'd1);
        chk({"R4 bd ", when}, {31'd0, cause_bd}, {31'd0, m_bd});
        chk({"R4 epc ", when}, epc, m_epc);
        chk({"R5 code ", when}, {27'd0, cause_code}, {27'd0, m_code});
        chk({"R6 ce ", when}, {30'd0, cause_ce}, {30'd0, m_ce});
        chk({"R10 badvaddr ", when}, bad_vaddr, m_bva);
        chk({"R11 vpn2 ", when}, {13'd0, entryhi_vpn2}, {13'd0, m_vpn});
        chk({"R11 ctx ", when}, {13'd0, context_badvpn2}, {13'd0, m_ctx});
        chk({"R11 asid ", when}, {24'd0, entryhi_asid}, {24'd0, m_asid});
        chk({"R12 sets ", when}, {24'd0, srs_cur, srs_prev}, {24'd0, m_css, m_pss});
    endtask

    task automatic do_reset();
        req_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_exl = 0; m_bd = 0; m_code = 0; m_ce = 0; m_epc = 0; m_bva = 0;
        m_vpn = 0; m_ctx = 0; m_asid = 0; m_css = 0; m_pss = 0;
        @(negedge clk);
        chk("R1 boot pulse", {31'd0, redir_valid}, 32'd1);
        chk("R1 boot pc", redir_pc, 32'hBFC0_0000);
        chk("R1 boot npc", redir_npc, 32'hBFC0_0004);
        chk("R1 boot nnpc", redir_nnpc, 32'hBFC0_0008);
        check_state("after reset");
        @(negedge clk);
        chk("R1 boot pulse ends", {31'd0, redir_valid}, 32'd0);
    endtask

    // issue one request at a negedge; optionally poke a second one during the pulse
    task automatic do_req(input logic [3:0] c, input logic [31:0] pc, input logic [31:0] npc,
                          input logic [31:0] ba, input logic [1:0] cop, input logic [31:0] base,
                          input logic bev, input logic iv, input logic [7:0] asid,
                          input logic [3:0] ess);
        logic [31:0] h;
        req_class = c; req_pc = pc; req_next_pc = npc; req_bad_addr = ba;
        req_cop_id = cop; cfg_ebase = base; cfg_bev = bev; cfg_iv = iv;
        cfg_asid = asid; cfg_exc_set = ess; req_valid = 1'b1;
        if (c <= 4'd13) begin
            h = exp_handler(c, m_exl, bev, iv, base);
            if (!m_exl && !bev) begin m_pss = m_css; m_css = ess; end
            m_exl  = 1'b1;
            m_bd   = (pc + 32'd4) != npc;
            m_epc  = m_bd ? pc - 32'd4 : pc;
            m_code = exp_code(c);
            m_ce   = (c == 4'd11) ? cop : 2'd0;
            if (c >= 4'd1 && c <= 4'd7) m_bva = ba;
            if (c >= 4'd1 && c <= 4'd5) begin
                m_vpn = ba[31:13]; m_ctx = ba[31:13]; m_asid = asid;
            end
            @(negedge clk);
            chk("R2 pulse on accept", {31'd0, redir_valid}, 32'd1);
            chk("R7 R8 R9 handler", redir_pc, h);
            chk("R13 npc", redir_npc, h + 32'd4);
            chk("R13 nnpc", redir_nnpc, h + 32'd8);
            check_state("entry");
            // a request during the pulse must be dropped
            req_class = 4'd8; req_pc = pc + 32'h40; req_next_pc = pc + 32'h100;
            req_bad_addr = ~ba;
            @(negedge clk);
            req_valid = 1'b0;
            chk("R2 busy request dropped", {31'd0, redir_valid}, 32'd0);
            check_state("busy drop");
        end else begin
            @(negedge clk);
            req_valid = 1'b0;
            chk("R2 illegal class dropped", {31'd0, redir_valid}, 32'd0);
            check_state("illegal");
        end
    endtask

    initial begin
        #(1_000_000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] pc, npc, base;
        void'($urandom(32'd4242));
        do_reset();
        // R7 general vector, sequential successor
        do_req(4'd8, 32'h0040_1000, 32'h0040_1004, 32'h0, 2'd0, 32'h8000_0000, 0, 0, 8'h11, 4'd5);
        // R12 second entry with EXL set: selectors hold; R4 delay slot
        do_req(4'd9, 32'h0040_2000, 32'h0040_3000, 32'h0, 2'd0, 32'h8000_0000, 0, 0, 8'h11, 4'd7);
        // R8 refill with EXL already 1
        do_req(4'd2, 32'h0040_2100, 32'h0040_2104, 32'h1234_5678, 2'd0, 32'h8000_0000, 0, 0, 8'h22, 4'd1);
        do_reset();
        // R8 refill with EXL clear goes to base + 0, R11 store refill
        do_req(4'd4, 32'h0040_2200, 32'h0040_2204, 32'hDEAD_B000, 2'd0, 32'h9000_0000, 0, 0, 8'h33, 4'd3);
        // R6 coprocessor id captured, then cleared
        do_req(4'd11, 32'h0040_2300, 32'h0040_2304, 32'h0, 2'd3, 32'h9000_0000, 0, 0, 8'h33, 4'd3);
        do_req(4'd12, 32'h0040_2400, 32'h0040_2404, 32'h0, 2'd2, 32'h9000_0000, 0, 0, 8'h33, 4'd3);
        // R9 interrupt vector
        do_req(4'd0, 32'h0040_2500, 32'h0040_2504, 32'h0, 2'd0, 32'h9000_0000, 0, 1, 8'h33, 4'd3);
        // R2 illegal classes
        do_req(4'd14, 32'h0040_2600, 32'h0040_2604, 32'h5555_0000, 2'd1, 32'h9000_0000, 0, 0, 8'h44, 4'd2);
        do_req(4'd15, 32'h0040_2700, 32'h0040_2704, 32'h5555_0000, 2'd1, 32'h9000_0000, 0, 0, 8'h44, 4'd2);
        do_reset();
        // R7 boot vectors, R12 no rotation under BEV
        do_req(4'd2, 32'h0040_2800, 32'h0040_2804, 32'h0F0F_0000, 2'd0, 32'h9000_0000, 1, 1, 8'h55, 4'd9);
        for (int i = 0; i < 160; i++) begin
            if ($urandom_range(0, 4) == 0) do_reset();
            pc   = {$urandom_range(0, 32'h3FFF_FFFF), 2'b00};
            npc  = ($urandom_range(0, 1) == 0) ? pc + 32'd4 : {$urandom_range(0, 32'h3FFF_FFFF), 2'b00};
            base = {2'b10, 18'($urandom), 12'h000};
            do_req(4'($urandom_range(0, 15)), pc, npc, $urandom, 2'($urandom),
                   base, ($urandom_range(0, 3) == 0), 1'($urandom), 8'($urandom), 4'($urandom));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule